// File: doc/BRIEF.md
# Stepped Period and Duty PWM Generator

This block drives one PWM pin from an up-counting time base. The period and the compare threshold both change on every PWM cycle. They follow a 12-step table that repeats without end. The system clock is first divided down to a counter tick. The counter runs from zero up to the active period and then wraps.

The pin rises on the tick after the counter meets the compare value. It falls on the tick that wraps the counter. The high time of a cycle is therefore the period minus the compare, in ticks.

The active period and compare sit behind a pair of shadow registers. A built-in sequencer refills the shadows from the table on each period match. Both active values are replaced together on the same edge that returns the counter to zero. As a result, every cycle runs entirely on one table step.

A one-clock event strobe marks each period match. It can serve as an interrupt request or an ADC start-of-conversion trigger. An optional write port replaces table entries at run time.

Top module: `stepped_pwm`

## Requirements
- R1: After reset the step index is 1, the PWM output is low and the event strobe is low. The counter starts at 0, and step 1 is active.
- R2: The counter advances once every DIV system clocks while `en` is high (DIV defaults to 2). It counts from 0 to the active period P and then wraps to 0, so one cycle lasts DIV*(P+1) clocks.
- R3: With compare C below period P, the output goes high on the tick that leaves count C. It goes low on the tick that wraps the counter, so it is high for DIV*(P−C) clocks per cycle, and a falling edge only ever coincides with the event strobe.
- R4: When C is greater than or equal to P, the output stays low for the whole cycle. If both matches fall on the same tick, the period match wins.
- R5: `evt_o` is high for exactly one clock after each period match. That clock is the first clock of the new cycle, in which the counter is 0.
- R6: `step_o` advances 1, 2, …, 12 and then back to 1, changing only together with `evt_o`. The default table of (period, compare) pairs is, by step: 1:(173,130) 2:(393,267) 3:(373,178) 4:(323,107) 5:(251,50) 6:(337,37) 7:(336,36) 8:(237,37) 9:(266,50) 10:(302,107) 11:(304,178) 12:(311,267).
- R7: The period and compare of a step are loaded together into the active pair on the wrap edge that starts that step. No cycle ever mixes the values of two steps.
- R8: A write with `tbl_we` high and `tbl_idx` between 1 and 12 replaces that step's period and compare. The new values are used from that step's next fetch. Fetches run one cycle ahead, so the step after the current one is already in the shadows.
- R9: A table write with `tbl_idx` equal to 0 or to 13..15 changes nothing.
- R10: While `en` is low, the counter, the output and the step index hold, and no event is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable for the prescaler and time base |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 4 | Step number to overwrite (1..12) |
| tbl_per | input | CW | Period value for the write |
| tbl_cmp | input | CW | Compare value for the write |
| pwm_o | output | 1 | PWM pin |
| evt_o | output | 1 | One-clock period-match event strobe |
| step_o | output | 4 | Step whose values are currently active |

## Verification
A fault in the shadow or sequencer path shows up within one PWM cycle. A step would then have the wrong total length or the wrong high time. The bench measures every cycle in clocks between two event strobes and compares both numbers against the table for 36 consecutive cycles. A compare value left behind by one cycle would show up as a wrong high time, even where the period is right. A stuck or late prescaler stretches the first measured cycle. Enable and table-write faults show up as a moved pin or step index during a frozen window, or as a wrong cycle for an overwritten step on the first pass.

// File: rtl/stepped_pwm.sv
`timescale 1ns/1ps
module stepped_pwm #(
  parameter int CW  = 16,
  parameter int DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tbl_we,
  input  logic [3:0]    tbl_idx,
  input  logic [CW-1:0] tbl_per,
  input  logic [CW-1:0] tbl_cmp,
  output logic          pwm_o,
  output logic          evt_o,
  output logic [3:0]    step_o
);
  localparam int STEPS = 12;
  localparam int DW    = (DIV > 1) ? $clog2(DIV) : 1;

  function automatic logic [CW-1:0] base_per(input int i);
    case (i)
      0: return CW'(173);  1: return CW'(393);  2: return CW'(373);
      3: return CW'(323);  4: return CW'(251);  5: return CW'(337);
      6: return CW'(336);  7: return CW'(237);  8: return CW'(266);
      9: return CW'(302); 10: return CW'(304); default: return CW'(311);
    endcase
  endfunction

  function automatic logic [CW-1:0] base_cmp(input int i);
    case (i)
      0: return CW'(130);  1: return CW'(267);  2: return CW'(178);
      3: return CW'(107);  4: return CW'(50);   5: return CW'(37);
      6: return CW'(36);   7: return CW'(37);   8: return CW'(50);
      9: return CW'(107); 10: return CW'(178); default: return CW'(267);
    endcase
  endfunction

  function automatic logic [3:0] after(input logic [3:0] s);
    return (s == 4'(STEPS)) ? 4'd1 : s + 4'd1;
  endfunction

  logic [DW-1:0] div_q;
  logic [CW-1:0] ctr, act_per, act_cmp, sh_per, sh_cmp;
  logic [CW-1:0] per_tab [STEPS];
  logic [CW-1:0] cmp_tab [STEPS];
  logic [3:0]    fetch;

  wire tick    = en && (div_q == DW'(DIV - 1));
  wire prd_hit = tick && (ctr == act_per);
  wire cmp_hit = tick && (ctr == act_cmp);
  assign fetch = after(after(step_o)) - 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STEPS; i++) begin
        per_tab[i] <= base_per(i);
        cmp_tab[i] <= base_cmp(i);
      end
    end else begin
      for (int i = 0; i < STEPS; i++)
        if (tbl_we && tbl_idx == 4'(i + 1)) begin
          per_tab[i] <= tbl_per;
          cmp_tab[i] <= tbl_cmp;
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ctr     <= '0;
      act_per <= base_per(0);
      act_cmp <= base_cmp(0);
      sh_per  <= base_per(1);
      sh_cmp  <= base_cmp(1);
      step_o  <= 4'd1;
      pwm_o   <= 1'b0;
      evt_o   <= 1'b0;
    end else begin
      if (en) div_q <= tick ? '0 : div_q + 1'b1;
      evt_o <= prd_hit;
      if (prd_hit) begin
        ctr     <= '0;
        act_per <= sh_per;
        act_cmp <= sh_cmp;
        sh_per  <= per_tab[fetch];
        sh_cmp  <= cmp_tab[fetch];
        step_o  <= after(step_o);
        pwm_o   <= 1'b0;
      end else if (tick) begin
        ctr <= ctr + 1'b1;
        if (cmp_hit) pwm_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stepped_pwm_chk.sv
`timescale 1ns/1ps
module stepped_pwm_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pwm_o,
  input logic          evt_o,
  input logic [3:0]    step_o,
  input logic [CW-1:0] ctr,
  input logic [CW-1:0] act_per
);
  // R2
  ctr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr <= act_per);

  // R5
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);

  // R5
  evt_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> ctr == '0);

  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o >= 4'd1 && step_o <= 4'd12);

  // R6
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> step_o == (($past(step_o) == 4'd12) ? 4'd1 : $past(step_o) + 4'd1));

  // R7
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_o |-> $stable(step_o));

  // R3
  pwm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_o) |-> evt_o);

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pwm_o) && $stable(ctr) && !evt_o));
endmodule

bind stepped_pwm stepped_pwm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_o(pwm_o), .evt_o(evt_o),
  .step_o(step_o), .ctr(ctr), .act_per(act_per)
);

// File: tb/tb_stepped_pwm.sv
`timescale 1ns/1ps
module tb_stepped_pwm;
  localparam int CW  = 16;
  localparam int DIV = 2;
  localparam int BASE_PER [12] = '{173,393,373,323,251,337,336,237,266,302,304,311};
  localparam int BASE_CMP [12] = '{130,267,178,107,50,37,36,37,50,107,178,267};

  logic clk = 0, rst_n = 0, en = 0, tbl_we = 0;
  logic [3:0] tbl_idx = '0;
  logic [CW-1:0] tbl_per = '0, tbl_cmp = '0;
  logic pwm_o, evt_o;
  logic [3:0] step_o;

  int checks = 0, errors = 0;
  int exp_per [12];
  int exp_cmp [12];

  always #10 clk = ~clk;

  stepped_pwm #(.CW(CW), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_per(tbl_per), .tbl_cmp(tbl_cmp), .pwm_o(pwm_o), .evt_o(evt_o), .step_o(step_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic twrite(input int idx, input int p, input int c);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 4'(idx); tbl_per = CW'(p); tbl_cmp = CW'(c);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic wait_evt();
    do @(negedge clk); while (!evt_o);
  endtask

  task automatic run_cycle(output int st, output int hi, output int tot);
    st = step_o; hi = 0; tot = 0;
    do begin
      if (pwm_o) hi++;
      tot++;
      @(negedge clk);
    end while (!evt_o);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int st, hi, tot, exp_step, p, c;
    for (int i = 0; i < 12; i++) begin exp_per[i] = BASE_PER[i]; exp_cmp[i] = BASE_CMP[i]; end

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(step_o == 4'd1, "R1 step", int'(step_o), 1);
    chk(pwm_o == 1'b0, "R1 pwm", int'(pwm_o), 0);
    chk(evt_o == 1'b0, "R1 evt", int'(evt_o), 0);

    // R8 overwrite steps 5, 7, 9; R4 step 7 has C == P; step 9 has C == 0
    twrite(5, 99, 40);  exp_per[4] = 99; exp_cmp[4] = 40;
    twrite(7, 80, 80);  exp_per[6] = 80; exp_cmp[6] = 80;
    twrite(9, 60, 0);   exp_per[8] = 60; exp_cmp[8] = 0;
    // R9 out-of-range indices must change nothing
    twrite(13, 5, 1);
    twrite(0, 5, 1);
    twrite(15, 7, 2);
    // R10 nothing moves while disabled
    chk(step_o == 4'd1 && pwm_o == 1'b0, "R10 idle", int'(step_o), 1);

    en = 1;
    wait_evt();
    exp_step = 2;
    // R2 R3 R4 R6 R7 R8 R9: every cycle measured against its own table step
    for (int n = 0; n < 36; n++) begin
      run_cycle(st, hi, tot);
      p = exp_per[exp_step-1];
      c = exp_cmp[exp_step-1];
      chk(st == exp_step, "R6 step order", st, exp_step);
      chk(tot == DIV*(p+1), "R2 cycle length", tot, DIV*(p+1));
      if (c < p) chk(hi == DIV*(p-c), "R3 high time", hi, DIV*(p-c));
      else       chk(hi == 0, "R4 all-low cycle", hi, 0);
      exp_step = (exp_step == 12) ? 1 : exp_step + 1;
    end

    // R5 event is a single clock at counter zero, new cycle starts low
    chk(pwm_o == 1'b0, "R5 low at wrap", int'(pwm_o), 0);
    @(negedge clk);
    chk(evt_o == 1'b0, "R5 pulse width", int'(evt_o), 0);

    // R10 freeze mid-cycle
    repeat (30) @(negedge clk);
    en = 0;
    @(negedge clk);
    begin
      logic pw; logic [3:0] sv; int evts;
      pw = pwm_o; sv = step_o; evts = 0;
      repeat (40) begin @(negedge clk); if (evt_o) evts++; end
      chk(pwm_o == pw, "R10 pwm hold", int'(pwm_o), int'(pw));
      chk(step_o == sv, "R10 step hold", int'(step_o), int'(sv));
      chk(evts == 0, "R10 no event", evts, 0);
    end
    en = 1;
    wait_evt();
    // R7 after resuming, the next full cycle still matches its step exactly
    exp_step = int'(step_o);
    run_cycle(st, hi, tot);
    p = exp_per[exp_step-1];
    c = exp_cmp[exp_step-1];
    chk(tot == DIV*(p+1), "R7 length after freeze", tot, DIV*(p+1));
    if (c < p) chk(hi == DIV*(p-c), "R7 high after freeze", hi, DIV*(p-c));
    else       chk(hi == 0, "R7 high after freeze", hi, 0);

    finish_up();
  end
endmodule